// File: doc/BRIEF.md
# One-Shot Pulse Timer

This block is a 16-bit up-counting timer with a one-shot output. When one-pulse mode is on and the selected edge arrives on the capture input, the counter restarts from 16'hFFFC and output pin 1 takes the "during" level. When the count reaches the compare-1 value, pin 1 returns to the "after" level. The pulse is therefore `((cmp1 - 16'hFFFC) mod 2^16) * N + 1` system clock cycles long, where N is the prescale factor. The restart also clears the prescaler phase, so the pulse width does not depend on when the edge arrives.

A second compare channel drives pin 2 and raises its own flag in every mode. Each pin has a sticky forced-compare path. Once it is requested, the pin follows its level input directly until reset, and no flag is raised. The capture flag and the compare flags can each be cleared, and they are combined into one interrupt line through two enables. The enable that selects PWM takes priority over one-pulse mode: while it is set, capture edges do not restart the counter.

Top module: `pulse_timer`

## Requirements
- R1: After reset the counter reads 16'hFFFC, all three flags and the interrupt are 0, pin 1 shows the after-level `lvl1_i` when enabled, and pin 2 is 0.
- R2: The capture input passes through a two-flop synchroniser. With `edge_rise_i`=1 only rising transitions are active, and with 0 only falling ones. Every active edge sets the capture flag in any mode, and inactive transitions leave the flag unchanged.
- R3: In one-pulse mode, an active edge loads 16'hFFFC into the counter three clock cycles after the input changes, and pin 1 switches to `lvl2_i`. Pin 1 returns to `lvl1_i` one cycle after the counter equals `cmp1_i`, which gives the pulse width stated above.
- R4: `clk_sel_i` selects the counter rate: 2'b00 divides by 4, 2'b01 divides by 2, 2'b10 divides by 8, and 2'b11 stops the counter.
- R5: In one-pulse mode the compare-1 flag is never set. Outside one-pulse mode a compare-1 match sets it.
- R6: A compare-2 match sets the compare-2 flag and loads `lvl2_i` into pin 2, including in one-pulse mode.
- R7: While `pwm_en_i`=1, active edges neither reload the counter nor start a pulse, even if `opm_en_i`=1.
- R8: A pulse on `forceN_i` latches forcing for pin N until reset. While forced, pin 1 follows `lvl1_i` and pin 2 follows `lvl2_i`, with no flag set. In one-pulse mode a triggered pulse does not appear on a forced pin 1.
- R9: A pin whose enable (`oe1_i` or `oe2_i`) is 0 drives 0.
- R10: `irq_o` = (capture flag AND `cap_ie_i`) OR ((compare-1 flag OR compare-2 flag) AND `cmp_ie_i`).
- R11: When a restart and a compare-1 match fall in the same cycle, the restart wins and pin 1 stays at `lvl2_i`. When a flag set and its clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_i | input | 1 | Capture input (asynchronous) |
| edge_rise_i | input | 1 | 1 = rising edge active, 0 = falling edge active |
| clk_sel_i | input | 2 | Counter rate select |
| opm_en_i | input | 1 | One-pulse mode enable |
| pwm_en_i | input | 1 | PWM select; overrides one-pulse mode |
| oe1_i | input | 1 | Pin 1 output enable |
| oe2_i | input | 1 | Pin 2 output enable |
| lvl1_i | input | 1 | After-pulse level / forced level of pin 1 |
| lvl2_i | input | 1 | During-pulse level / compare-2 and forced level of pin 2 |
| force1_i | input | 1 | Forced-compare request, pin 1 |
| force2_i | input | 1 | Forced-compare request, pin 2 |
| cmp1_i | input | 16 | Compare-1 value (pulse end) |
| cmp2_i | input | 16 | Compare-2 value |
| cap_ie_i | input | 1 | Capture interrupt enable |
| cmp_ie_i | input | 1 | Compare interrupt enable |
| cap_clr_i | input | 1 | Clear capture flag |
| cmp_clr_i | input | 1 | Clear both compare flags |
| cnt_o | output | 16 | Counter value |
| out1_o | output | 1 | Pin 1 |
| out2_o | output | 1 | Pin 2 |
| cap_flag_o | output | 1 | Capture flag |
| cmp1_flag_o | output | 1 | Compare-1 flag |
| cmp2_flag_o | output | 1 | Compare-2 flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The restart caused by a capture edge can fall in the same cycle as the compare-1 match that ends the pulse. The bench sets up this collision with a divide-by-2 rate, a compare value one above the restart value, and a second rising edge placed three cycles after the first. It then counts the cycles that pin 1 spends at the during-level: six cycles shows that the restart won, and three shows that the match won. A second collision puts the capture-flag clear in the same cycle as the edge event, and the bench checks that the flag reads 1 afterwards.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;
  typedef enum logic [1:0] {
    CK_DIV4 = 2'b00,
    CK_DIV2 = 2'b01,
    CK_DIV8 = 2'b10,
    CK_STOP = 2'b11
  } ck_sel_e;

  localparam int PRE_W  = 3;
  localparam int SYNC_N = 2;
  localparam int N_CMP  = 2;
endpackage

// File: rtl/pulse_timer_presc.sv
module pulse_timer_presc
  import pulse_timer_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ck_sel_e sel_i,
  input  logic    clr_i,
  output logic    tick_o
);
  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else            pre_q <= pre_q + PW'(1);
  end

  always_comb begin
    unique case (sel_i)
      CK_DIV2: tick_o = pre_q[0];
      CK_DIV4: tick_o = &pre_q[1:0];
      CK_DIV8: tick_o = &pre_q[2:0];
      default: tick_o = 1'b0;
    endcase
  end

  assert_div2_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == CK_DIV2 && tick_o && !clr_i) |=> !tick_o);
endmodule

// File: rtl/pulse_timer_capsync.sv
module pulse_timer_capsync
  import pulse_timer_pkg::*;
#(
  parameter int SN = SYNC_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  // sh_q[SN-1] is the synchronised level, sh_q[SN] its previous value
  logic [SN:0] sh_q;
  logic        now_l, prev_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SN-1:0], cap_i};
  end

  assign now_l  = sh_q[SN-1];
  assign prev_l = sh_q[SN];
  assign evt_o  = rise_sel_i ? (now_l & ~prev_l) : (~now_l & prev_l);

  assert_evt_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/pulse_timer_cnt.sv
module pulse_timer_cnt
  import pulse_timer_pkg::*;
#(
  parameter int CW = 16,
  parameter int NC = N_CMP
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   reload_i,
  input  logic [NC-1:0][CW-1:0]  cmp_i,
  output logic [CW-1:0]          cnt_o,
  output logic [NC-1:0]          hit_o
);
  localparam logic [CW-1:0] RELOAD = ~CW'(3);

  logic [CW-1:0] cnt_q;
  logic          fresh_q;  // counter took a new value on the last edge

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= RELOAD;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= tick_i | reload_i;
      if (reload_i)    cnt_q <= RELOAD;
      else if (tick_i) cnt_q <= cnt_q + CW'(1);
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_cmp
    assign hit_o[g] = fresh_q && (cnt_q == cmp_i[g]);
  end

  assign cnt_o = cnt_q;

  assert_reload_val_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_o == RELOAD);
  assert_hold_no_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && !tick_i) |=> $stable(cnt_o));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             edge_rise_i,
  input  logic [1:0]       clk_sel_i,
  input  logic             opm_en_i,
  input  logic             pwm_en_i,
  input  logic             oe1_i,
  input  logic             oe2_i,
  input  logic             lvl1_i,
  input  logic             lvl2_i,
  input  logic             force1_i,
  input  logic             force2_i,
  input  logic [CNT_W-1:0] cmp1_i,
  input  logic [CNT_W-1:0] cmp2_i,
  input  logic             cap_ie_i,
  input  logic             cmp_ie_i,
  input  logic             cap_clr_i,
  input  logic             cmp_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             out1_o,
  output logic             out2_o,
  output logic             cap_flag_o,
  output logic             cmp1_flag_o,
  output logic             cmp2_flag_o,
  output logic             irq_o
);
  logic                         tick, evt, reload, opm_act;
  logic [N_CMP-1:0]             hit, cmp_set, cmp_flag_q, frc_q;
  logic [N_CMP-1:0][CNT_W-1:0]  cmp_pair;
  logic                         during_q, pin2_q, cap_flag_q;

  assign opm_act  = opm_en_i & ~pwm_en_i;  // PWM select overrides one-pulse
  assign reload   = evt & opm_act;
  assign cmp_pair = {cmp2_i, cmp1_i};
  assign cmp_set  = {hit[1], hit[0] & ~opm_act};

  pulse_timer_presc u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (ck_sel_e'(clk_sel_i)),
    .clr_i  (reload),
    .tick_o (tick)
  );

  pulse_timer_capsync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_i),
    .rise_sel_i (edge_rise_i),
    .evt_o      (evt)
  );

  pulse_timer_cnt #(.CW(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .reload_i (reload),
    .cmp_i    (cmp_pair),
    .cnt_o    (cnt_o),
    .hit_o    (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      during_q   <= 1'b0;
      pin2_q     <= 1'b0;
      frc_q      <= '0;
      cap_flag_q <= 1'b0;
      cmp_flag_q <= '0;
    end else begin
      if (reload)      during_q <= 1'b1;  // restart beats end-of-pulse match
      else if (hit[0]) during_q <= 1'b0;
      if (hit[1]) pin2_q <= lvl2_i;
      frc_q <= frc_q | {force2_i, force1_i};
      if (evt)            cap_flag_q <= 1'b1;
      else if (cap_clr_i) cap_flag_q <= 1'b0;
      for (int i = 0; i < N_CMP; i++) begin
        if (cmp_set[i])     cmp_flag_q[i] <= 1'b1;
        else if (cmp_clr_i) cmp_flag_q[i] <= 1'b0;
      end
    end
  end

  assign out1_o = oe1_i & (frc_q[0] ? lvl1_i : (during_q ? lvl2_i : lvl1_i));
  assign out2_o = oe2_i & (frc_q[1] ? lvl2_i : pin2_q);

  assign cap_flag_o  = cap_flag_q;
  assign cmp1_flag_o = cmp_flag_q[0];
  assign cmp2_flag_o = cmp_flag_q[1];
  assign irq_o = (cap_flag_q & cap_ie_i) | ((|cmp_flag_q) & cmp_ie_i);

  assert_no_cmp1_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opm_act && !cmp_flag_q[0]) |=> !cmp_flag_q[0]);
  assert_pwm_no_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i && !during_q) |=> !during_q);
  assert_force_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_q[0] && oe1_i) |-> out1_o == lvl1_i);
  assert_force_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_q[0] |=> frc_q[0]);
  assert_oe_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe1_i |-> !out1_o) and (!oe2_i |-> !out2_o));
  assert_restart_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> during_q);
  assert_cap_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> cap_flag_q);
endmodule

// File: tb/pulse_timer_bench.sv
module pulse_timer_bench;
  localparam logic [15:0] RELOAD = 16'hFFFC;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cap_i = 0, edge_rise_i = 1, opm_en_i = 0, pwm_en_i = 0;
  logic [1:0]  clk_sel_i = 2'b11;
  logic        oe1_i = 1, oe2_i = 1, lvl1_i = 1, lvl2_i = 0;
  logic        force1_i = 0, force2_i = 0, cap_ie_i = 0, cmp_ie_i = 0;
  logic        cap_clr_i = 0, cmp_clr_i = 0;
  logic [15:0] cmp1_i = 16'h0100, cmp2_i = 16'h0200;
  logic [15:0] cnt_o;
  logic        out1_o, out2_o, cap_flag_o, cmp1_flag_o, cmp2_flag_o, irq_o;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  pulse_timer u_pulse_timer (
    .clk_i(clk), .rst_ni(rst_ni), .cap_i(cap_i), .edge_rise_i(edge_rise_i),
    .clk_sel_i(clk_sel_i), .opm_en_i(opm_en_i), .pwm_en_i(pwm_en_i),
    .oe1_i(oe1_i), .oe2_i(oe2_i), .lvl1_i(lvl1_i), .lvl2_i(lvl2_i),
    .force1_i(force1_i), .force2_i(force2_i), .cmp1_i(cmp1_i), .cmp2_i(cmp2_i),
    .cap_ie_i(cap_ie_i), .cmp_ie_i(cmp_ie_i), .cap_clr_i(cap_clr_i),
    .cmp_clr_i(cmp_clr_i), .cnt_o(cnt_o), .out1_o(out1_o), .out2_o(out2_o),
    .cap_flag_o(cap_flag_o), .cmp1_flag_o(cmp1_flag_o),
    .cmp2_flag_o(cmp2_flag_o), .irq_o(irq_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_flags();
    cap_clr_i = 1; cmp_clr_i = 1; step(1);
    cap_clr_i = 0; cmp_clr_i = 0;
  endtask

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'b00:   return 4;
      2'b01:   return 2;
      2'b10:   return 8;
      default: return 0;
    endcase
  endfunction

  initial begin
    int c;
    int highs;
    step(3);
    rst_ni = 1;
    step(1);
    // R1 reset state
    chk("R1", "cnt", cnt_o, RELOAD);
    chk("R1", "flags", {cap_flag_o, cmp1_flag_o, cmp2_flag_o}, 0);
    chk("R1", "out1", out1_o, 1);
    chk("R1", "out2", out2_o, 0);
    chk("R1", "irq", irq_o, 0);
    // R9 enable gates pin
    oe1_i = 0; step(1);
    chk("R9", "out1 disabled", out1_o, 0);
    oe1_i = 1;
    // R4 run then stop
    clk_sel_i = 2'b01; step(7);
    clk_sel_i = 2'b11; step(2);
    c = cnt_o;
    chk("R4", "counter advanced", (c != RELOAD), 1);
    // R2 edge selection, stopped clock, normal mode
    cap_i = 1; step(5);
    chk("R2", "rising sets flag", cap_flag_o, 1);
    chk("R4", "stop holds count", cnt_o, c);
    chk("R10", "irq off without enable", irq_o, 0);
    cap_ie_i = 1; step(1);
    chk("R10", "irq with cap enable", irq_o, 1);
    cap_ie_i = 0;
    clr_flags();
    cap_i = 0; step(5);
    chk("R2", "falling ignored", cap_flag_o, 0);
    edge_rise_i = 0; step(1);
    cap_i = 1; step(5);
    chk("R2", "rising ignored in fall mode", cap_flag_o, 0);
    cap_i = 0; step(5);
    chk("R2", "falling sets flag", cap_flag_o, 1);
    clr_flags();
    edge_rise_i = 1; step(2);
    // R11 set beats clear
    cap_i = 1; step(2);
    cap_clr_i = 1; step(1);
    cap_clr_i = 0;
    chk("R11", "cap set over clear", cap_flag_o, 1);
    clr_flags();
    cap_i = 0; step(3);
    // R7 pwm override
    opm_en_i = 1; pwm_en_i = 1; lvl1_i = 0; lvl2_i = 1; cmp1_i = RELOAD + 2;
    step(1);
    cap_i = 1; step(5);
    chk("R7", "no reload under pwm", cnt_o, c);
    chk("R7", "no pulse under pwm", out1_o, 0);
    cap_i = 0; step(3);
    // R3 reload with stopped clock
    pwm_en_i = 0; step(1);
    cap_i = 1; step(3);
    chk("R3", "reload value", cnt_o, RELOAD);
    chk("R3", "during level", out1_o, 1);
    cap_i = 0;
    clk_sel_i = 2'b01; step(20);
    chk("R3", "after level", out1_o, 0);
    chk("R5", "no cmp1 flag in opm", cmp1_flag_o, 0);
    // R3/R4 pulse width sweep
    for (int e = 1; e >= 0; e--) begin
      if (e == 1) begin edge_rise_i = 1; step(1); cap_i = 0; end
      else begin cap_i = 1; step(1); edge_rise_i = 0; end
      for (int s = 0; s < 3; s++) begin
        for (int k = 0; k < 6; k++) begin
          logic [1:0] sv;
          sv = (s == 0) ? 2'b01 : (s == 1) ? 2'b00 : 2'b10;
          clk_sel_i = sv;
          cmp1_i = RELOAD + 16'(k);
          step(60);
          cap_i = e[0];
          highs = 0;
          for (int i = 0; i < 60; i++) begin
            step(1);
            if (out1_o) highs++;
          end
          chk("R3", $sformatf("width e%0d s%0b k%0d", e, sv, k),
              highs, k * div_of(sv) + 1);
          cap_i = ~e[0];
        end
      end
    end
    chk("R5", "no cmp1 flag after sweep", cmp1_flag_o, 0);
    // R11 restart collides with end match
    edge_rise_i = 1; step(1);
    cap_i = 0; clk_sel_i = 2'b01; cmp1_i = RELOAD + 1;
    step(60);
    cap_i = 1;
    highs = 0;
    for (int i = 1; i <= 40; i++) begin
      step(1);
      if (out1_o) highs++;
      if (i == 1) cap_i = 0;
      if (i == 3) cap_i = 1;
    end
    chk("R11", "restart wins over match", highs, 6);
    cap_i = 0;
    // R6 compare 2 in opm
    clr_flags();
    cmp2_i = RELOAD + 2; cmp1_i = RELOAD + 4; lvl2_i = 1;
    step(4);
    cap_i = 1; step(30);
    chk("R6", "cmp2 flag", cmp2_flag_o, 1);
    chk("R6", "pin2 level", out2_o, 1);
    chk("R5", "cmp1 flag in opm", cmp1_flag_o, 0);
    cap_clr_i = 1; step(1); cap_clr_i = 0;
    chk("R10", "irq off without cmp enable", irq_o, 0);
    cmp_ie_i = 1; step(1);
    chk("R10", "irq with cmp enable", irq_o, 1);
    cmp_ie_i = 0;
    cap_i = 0;
    // R5 normal mode sets cmp1 flag
    opm_en_i = 0; clr_flags();
    step(1);
    c = cnt_o;
    cmp1_i = 16'(c + 4);
    step(16);
    chk("R5", "cmp1 flag normal mode", cmp1_flag_o, 1);
    // R8 forced compare
    clk_sel_i = 2'b11; step(2);
    clr_flags();
    lvl1_i = 1; force1_i = 1; step(1);
    force1_i = 0; step(1);
    chk("R8", "forced pin1 high", out1_o, 1);
    lvl1_i = 0; step(1);
    chk("R8", "forced pin1 low", out1_o, 0);
    lvl1_i = 1; step(1);
    chk("R8", "forced pin1 toggles back", out1_o, 1);
    lvl2_i = 0; force2_i = 1; step(1);
    force2_i = 0; step(1);
    chk("R8", "forced pin2 follows low", out2_o, 0);
    lvl2_i = 1; step(1);
    chk("R8", "forced pin2 follows high", out2_o, 1);
    chk("R8", "no flags from force", {cmp1_flag_o, cmp2_flag_o}, 0);
    opm_en_i = 1; lvl1_i = 0; step(1);
    cap_i = 1; step(5);
    chk("R8", "forced pin1 ignores pulse", out1_o, 0);
    cap_i = 0;
    rst_ni = 0; step(2);
    rst_ni = 1; step(1);
    chk("R1", "pin2 low after reset", out2_o, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule